// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This unit watches eight general-purpose input lines and turns activity on them into interrupt requests. Each line is independently set up through bit-per-line registers on a byte-wide write bus: a trigger-kind bit chooses between level sensing and edge capture, a polarity bit chooses the active level or the active edge, an enable bit admits the line, and a debounce bit inserts a slow-tick filter. Captured edges stay pending until software writes a one to the line's bit in the acknowledge register.

Every pin passes through a synchronizer and an optional debounce filter before any decision is made. The per-line request vector is available both as a bank of individually routed interrupt outputs and as one combined interrupt. The request vector can also be read back over the bus. Detection on both edges is not built in. Software gets it by flipping the polarity bit after each capture.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register reads 0x00, the request register reads 0x00, and all interrupt outputs are low.
- R2: In level mode (kind bit 0) a line's request bit is 1 exactly while the filtered pin equals its polarity bit (1 = high active, 0 = low active), and it is not latched.
- R3: In edge mode (kind bit 1) a rising edge (polarity 1) or a falling edge (polarity 0) of the filtered pin sets the line's request bit, which stays set after the pin returns.
- R4: Writing a mask to offset 0x08 clears the pending edge of every line whose mask bit is 1, leaves the other lines alone, and offset 0x08 reads as 0x00.
- R5: A write to offset 0x08 has no effect on the request bit of a line in level mode.
- R6: A line whose enable bit is 0 shows 0 in the request register and on both interrupt outputs, and an edge that occurs while it is disabled is not captured.
- R7: A write to the kind register (0x00) or the polarity register (0x04) discards the pending edge of every line that is disabled at that moment, so the line does not raise a request when it is enabled again; without such a write the pending edge is kept.
- R8: With its debounce bit set, a line's filtered value changes only after two consecutive debounce-tick samples disagree with it; a disagreement seen on only one tick is dropped.
- R9: With debounce off, a pin change reaches a level-mode request bit on the third rising clock edge after it, through a two-stage synchronizer and the filter register.
- R10: The per-line outputs equal the request register, and the combined output is high exactly when any request bit is 1.
- R11: Register offsets are kind 0x00, polarity 0x04, acknowledge 0x08, enable 0x0C, request status 0x10 (read only), debounce 0x18; the configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Register byte offset for reads and writes |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Read data for the register at bus_addr |
| pins | input | 8 | Asynchronous input lines |
| dbnc_tick | input | 1 | Slow single-cycle sampling pulse for the debounce filter |
| irq_line | output | 8 | Per-line interrupt requests |
| irq_any | output | 1 | OR of all requests |

## Verification
The assertions assume that dbnc_tick is a single-cycle pulse and that pins are free of metastability once past the synchronizer, so a filtered value only moves on a tick for debounced lines and follows the last synchronizer stage for the others. The stimulus drives pins and the tick on falling clock edges, keeps every tick one cycle wide, and leaves several cycles between a pin change and the next tick so that each debounce sample sees a settled value. The edge-capture checks also rely on pins being low at reset, and the bench holds them low until the filter has settled.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_KIND = 5'h00;
    localparam logic [REG_AW-1:0] OFS_POL  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_ACK  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_EN   = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_STAT = 5'h10;
    localparam logic [REG_AW-1:0] OFS_DBNC = 5'h18;
endpackage

// File: rtl/gpint_regs.sv
module gpint_regs
    import gpint_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    input  logic [N_LINES-1:0] status,
    output logic [N_LINES-1:0] kind,
    output logic [N_LINES-1:0] pol,
    output logic [N_LINES-1:0] en,
    output logic [N_LINES-1:0] dbnc,
    output logic               ack_we,
    output logic [N_LINES-1:0] ack_mask,
    output logic               cfg_chg
);
    typedef struct packed {
        logic [N_LINES-1:0] kind;
        logic [N_LINES-1:0] pol;
        logic [N_LINES-1:0] en;
        logic [N_LINES-1:0] dbnc;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d   = cfg_q;
        ack_we  = 1'b0;
        cfg_chg = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                OFS_KIND: begin cfg_d.kind = bus_wdata; cfg_chg = 1'b1; end
                OFS_POL:  begin cfg_d.pol  = bus_wdata; cfg_chg = 1'b1; end
                OFS_ACK:  ack_we = 1'b1;
                OFS_EN:   cfg_d.en   = bus_wdata;
                OFS_DBNC: cfg_d.dbnc = bus_wdata;
                default:  ;
            endcase
        end
        case (bus_addr)
            OFS_KIND: bus_rdata = cfg_q.kind;
            OFS_POL:  bus_rdata = cfg_q.pol;
            OFS_EN:   bus_rdata = cfg_q.en;
            OFS_STAT: bus_rdata = status;
            OFS_DBNC: bus_rdata = cfg_q.dbnc;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign kind     = cfg_q.kind;
    assign pol      = cfg_q.pol;
    assign en       = cfg_q.en;
    assign dbnc     = cfg_q.dbnc;
    assign ack_mask = bus_wdata;

    // R11: an enable write lands in the register on the next edge
    a_r11_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_EN) |=> (en == $past(bus_wdata)));

    // R4: the acknowledge offset never alters configuration
    a_r4_ack_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ACK) |=> ($stable(kind) && $stable(pol) && $stable(en)));
endmodule

// File: rtl/gpint_filter.sv
module gpint_filter #(
    parameter int N_LINES     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pins,
    input  logic               tick,
    input  logic [N_LINES-1:0] dbnc,
    output logic [N_LINES-1:0] filt
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][N_LINES-1:0] sync;
        logic [N_LINES-1:0]                  filt;
        logic [N_LINES-1:0]                  seen;
    } flt_t;

    flt_t f_d, f_q;
    logic [N_LINES-1:0] smp;

    assign smp = f_q.sync[SYNC_STAGES-1];

    always_comb begin
        f_d = f_q;
        f_d.sync[0] = pins;
        for (int k = 1; k < SYNC_STAGES; k++) f_d.sync[k] = f_q.sync[k-1];
        for (int i = 0; i < N_LINES; i++) begin
            if (!dbnc[i]) begin
                f_d.filt[i] = smp[i];
                f_d.seen[i] = 1'b0;
            end else if (tick) begin
                if (smp[i] != f_q.filt[i]) begin
                    if (f_q.seen[i]) begin
                        f_d.filt[i] = smp[i];
                        f_d.seen[i] = 1'b0;
                    end else begin
                        f_d.seen[i] = 1'b1;
                    end
                end else begin
                    f_d.seen[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign filt = f_q.filt;

    // R9: undebounced lines copy the last synchronizer stage one edge later
    a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_q.filt ^ $past(smp)) & ~$past(dbnc)) == '0);

    // R8: debounced lines hold between ticks
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (((f_q.filt ^ $past(f_q.filt)) & $past(dbnc)) == '0));

    // R8: a debounced change needs an earlier disagreeing sample
    a_r8_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_q.filt ^ $past(f_q.filt)) & $past(dbnc) & ~$past(f_q.seen)) == '0);
endmodule

// File: rtl/gpint_detect.sv
module gpint_detect #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] filt,
    input  logic [N_LINES-1:0] kind,
    input  logic [N_LINES-1:0] pol,
    input  logic [N_LINES-1:0] en,
    input  logic               ack_we,
    input  logic [N_LINES-1:0] ack_mask,
    input  logic               cfg_chg,
    output logic [N_LINES-1:0] status
);
    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] lat;
    } det_t;

    det_t d_d, d_q;
    logic [N_LINES-1:0] rise, fall, hit;

    always_comb begin
        rise = filt & ~d_q.prev;
        fall = ~filt & d_q.prev;
        hit  = en & kind & ((pol & rise) | (~pol & fall));
        d_d      = d_q;
        d_d.prev = filt;
        if (ack_we)  d_d.lat = d_d.lat & ~ack_mask;
        if (cfg_chg) d_d.lat = d_d.lat & en;
        d_d.lat = d_d.lat | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign status = en & ((kind & d_q.lat) | (~kind & ~(filt ^ pol)));

    // R6: no edge is captured on a line that was disabled
    a_r6_no_capture_off: assert property (@(posedge clk) disable iff (!rst_n)
        (d_q.lat & ~$past(d_q.lat) & ~$past(en)) == '0);

    // R4: acknowledged lines are clear unless a fresh edge arrived
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((d_q.lat & $past(ack_mask & ~hit)) == '0));

    // R7: a mode write empties the pending edges of disabled lines
    a_r7_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> ((d_q.lat & ~$past(en)) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpint_pkg::*;
#(
    parameter int N_LINES     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    input  logic [N_LINES-1:0] pins,
    input  logic               dbnc_tick,
    output logic [N_LINES-1:0] irq_line,
    output logic               irq_any
);
    logic [N_LINES-1:0] kind, pol, en, dbnc, ack_mask, filt, status;
    logic               ack_we, cfg_chg;

    gpint_regs #(.N_LINES(N_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(status),
        .kind(kind), .pol(pol), .en(en), .dbnc(dbnc),
        .ack_we(ack_we), .ack_mask(ack_mask), .cfg_chg(cfg_chg)
    );

    gpint_filter #(.N_LINES(N_LINES), .SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk(clk), .rst_n(rst_n), .pins(pins), .tick(dbnc_tick),
        .dbnc(dbnc), .filt(filt)
    );

    gpint_detect #(.N_LINES(N_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .filt(filt), .kind(kind), .pol(pol),
        .en(en), .ack_we(ack_we), .ack_mask(ack_mask), .cfg_chg(cfg_chg),
        .status(status)
    );

    assign irq_line = status;
    assign irq_any  = |status;

    // R10: a request on an output always belongs to an enabled line
    a_r10_line_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line & ~en) == '0);

    // R5: level-mode requests are untouched by an acknowledge write
    a_r5_level_ignores_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && $stable(filt) && !cfg_chg) |=> ((($past(irq_line) ^ irq_line) & ~kind & $past(~kind) & $past(en) & en) == '0));
endmodule

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = 5'h0;
    logic [7:0] bus_wdata = 8'h0;
    logic [7:0] bus_rdata;
    logic [7:0] pins = 8'h0;
    logic       dbnc_tick = 1'b0;
    logic [7:0] irq_line;
    logic       irq_any;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gpio_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins(pins),
        .dbnc_tick(dbnc_tick), .irq_line(irq_line), .irq_any(irq_any)
    );

    typedef struct packed {
        logic       we;
        logic [4:0] addr;
        logic [7:0] wdata;
        logic [7:0] pins;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 5'h0C, 8'hFF, 8'h00, 8'hFF},  // R2 all low-active level
        '{1'b1, 5'h04, 8'hFF, 8'h00, 8'h00},  // R2 high-active, pins low
        '{1'b0, 5'h00, 8'h00, 8'h5A, 8'h5A},  // R2 follows pins
        '{1'b1, 5'h00, 8'hF0, 8'h5A, 8'h0A},  // R3 upper edge mode, no new edge
        '{1'b0, 5'h00, 8'h00, 8'hA5, 8'hA5},  // R3 rising edges on 7,5
        '{1'b0, 5'h00, 8'h00, 8'h00, 8'hA0},  // R3 latched after return
        '{1'b1, 5'h08, 8'h20, 8'h00, 8'h80},  // R4 ack line 5 only
        '{1'b1, 5'h04, 8'h0F, 8'h00, 8'h80},  // R3 upper now falling edge
        '{1'b0, 5'h00, 8'h00, 8'hF0, 8'h80},  // R3 rise ignored in falling mode
        '{1'b0, 5'h00, 8'h00, 8'h00, 8'hF0},  // R3 falling edges captured
        '{1'b1, 5'h08, 8'hFF, 8'h00, 8'h00},  // R4 ack all
        '{1'b1, 5'h00, 8'h00, 8'h00, 8'hF0},  // R2 all level, upper low-active
        '{1'b1, 5'h08, 8'hFF, 8'h00, 8'hF0}   // R5 ack ignored in level mode
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        dbnc_tick = 1'b1;
        @(negedge clk);
        dbnc_tick = 1'b0;
    endtask

    task automatic check_req(input string req, input logic [7:0] exp);
        logic [7:0] r;
        check(req, irq_line, exp);
        check(req, {7'h0, irq_any}, {7'h0, |exp});
        rd(5'h10, r);
        check(req, r, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        check("R1 irq_line", irq_line, 8'h00);
        check("R1 irq_any", {7'h0, irq_any}, 8'h00);
        foreach (VECS[0].addr[k]) begin end
        rd(5'h00, r); check("R1 kind", r, 8'h00);
        rd(5'h04, r); check("R1 pol", r, 8'h00);
        rd(5'h0C, r); check("R1 en", r, 8'h00);
        rd(5'h18, r); check("R1 dbnc", r, 8'h00);
        rd(5'h10, r); check("R1 status", r, 8'h00);

        // R11 readback and offsets
        wr(5'h00, 8'h3C); rd(5'h00, r); check("R11 kind readback", r, 8'h3C);
        wr(5'h18, 8'hA5); rd(5'h18, r); check("R11 dbnc readback", r, 8'hA5);
        rd(5'h08, r); check("R4 ack reads zero", r, 8'h00);
        wr(5'h00, 8'h00);
        wr(5'h18, 8'h00);

        // vector table: R2 R3 R4 R5 R10
        for (int v = 0; v < NVEC; v++) begin
            pins = VECS[v].pins;
            if (VECS[v].we) wr(VECS[v].addr, VECS[v].wdata);
            idle(6);
            check_req($sformatf("R10 vec%0d", v), VECS[v].exp);
        end

        // R9 synchronizer latency, line 0 high-active level
        wr(5'h04, 8'h01);
        wr(5'h0C, 8'h01);
        idle(6);
        check("R9 idle", irq_line, 8'h00);
        pins = 8'h01;
        @(negedge clk); @(negedge clk);
        check("R9 after two edges", irq_line, 8'h00);
        @(negedge clk);
        check("R9 after three edges", irq_line, 8'h01);

        // R8 debounce
        wr(5'h18, 8'h01);
        pins = 8'h00;
        idle(6);
        check("R8 no tick holds", irq_line, 8'h01);
        pulse_tick();
        check("R8 one sample holds", irq_line, 8'h01);
        pins = 8'h01;
        idle(4);
        pulse_tick();
        idle(2);
        check("R8 glitch dropped", irq_line, 8'h01);
        pins = 8'h00;
        idle(4);
        pulse_tick();
        idle(2);
        check("R8 first sample", irq_line, 8'h01);
        pulse_tick();
        idle(2);
        check("R8 second sample changes", irq_line, 8'h00);
        wr(5'h18, 8'h00);

        // R6 edge while disabled
        wr(5'h0C, 8'h00);
        wr(5'h00, 8'h01);
        wr(5'h04, 8'h01);
        idle(4);
        pins = 8'h01;
        idle(6);
        check_req("R6 disabled", 8'h00);
        wr(5'h0C, 8'h01);
        idle(3);
        check_req("R6 not captured", 8'h00);

        // R7 stale capture
        pins = 8'h00; idle(6);
        pins = 8'h01; idle(6);
        check_req("R7 captured", 8'h01);
        wr(5'h0C, 8'h00); idle(2);
        check_req("R7 masked", 8'h00);
        wr(5'h0C, 8'h01); idle(2);
        check_req("R7 kept", 8'h01);
        wr(5'h0C, 8'h00);
        wr(5'h04, 8'h01);
        wr(5'h0C, 8'h01); idle(2);
        check_req("R7 dropped", 8'h00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule